// File: doc/BRIEF.md
# Dual Execute Unit Issue and Completion Scheduler

This block controls an execute stage that has two functional units with different, fixed occupancies: a short unit that needs two cycles per operation and a long unit that needs four. Neither unit is pipelined and neither has an input queue. Decode hands over one instruction tag per cycle, together with a one-bit select that names the unit that must execute it. If the named unit is idle, or is finishing and hands its result on in the same cycle, the instruction is taken at once. Otherwise the block raises a stall, which decode and fetch use to hold their current contents. The arithmetic itself is not modelled: each unit just carries the tag through for its occupancy time.

Finished tags go to the memory stage one per cycle, in the order the units finish rather than in program order. A short operation issued after a long one can therefore leave first. If both units finish in the same cycle, the instruction that was issued earlier goes first. The other unit keeps its result, stays busy, and offers it again in the next cycle. Each unit shows a busy flag and the number of cycles it still needs.

Top module: `dual_exec_sched`

## Requirements
- R1: While reset is applied, and until the first instruction is issued after it, both remaining-cycle counters read 0, both busy flags are low and `done_valid` is low.
- R2: An instruction presented with `dec_valid` high is taken in that same cycle, with `stall` low, when its unit is idle or is handing its finished result to the output in that cycle.
- R3: `stall` is high exactly when `dec_valid` is high and the selected unit is busy and is not handing its result on in that cycle. With `dec_valid` low, `stall` is low.
- R4: When an instruction is taken in cycle c, its tag appears on `done_tag` in cycle c+2 for the short unit and in cycle c+4 for the long unit, unless R7 holds it back.
- R5: In the cycle after a unit takes an instruction, its remaining-cycle counter reads the unit latency. The counter then drops by one each cycle down to 1, and reads 0 once the result has been handed on. The busy flag is high exactly when the counter is not 0.
- R6: At most one result leaves per cycle. `done_unit` names the source unit, and results leave in finishing order, which may differ from issue order.
- R7: If both units are in their final cycle at the same time, the result of the instruction issued earlier is output. The other unit keeps the counter at 1 and stays busy, and its result leaves in the next cycle. While it is held, a new instruction for that unit stalls.
- R8: `dec_unit` = 0 selects the short unit and `dec_unit` = 1 selects the long unit. `unit_busy[0]` and `rem_a` belong to the short unit, and `unit_busy[1]` and `rem_b` belong to the long unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_tag | input | TAG_W | Tag of the presented instruction |
| dec_unit | input | 1 | Unit select: 0 short, 1 long |
| stall | output | 1 | Hold decode and fetch this cycle |
| done_valid | output | 1 | A finished tag is offered to the memory stage |
| done_tag | output | TAG_W | Finished tag |
| done_unit | output | 1 | Unit that produced the finished tag |
| unit_busy | output | 2 | Busy flag per unit |
| rem_a | output | CNT_W | Remaining cycles of the short unit |
| rem_b | output | CNT_W | Remaining cycles of the long unit |

## Verification
If a counter loads or steps wrongly, the fault shows on `rem_a` or `rem_b` in the next cycle. Within one latency period it then moves the cycle in which `stall` drops or `done_valid` rises. If the age flag is wrong, the only visible effect is at a same-cycle finish. There the wrong tag appears first and the other unit's counter empties one cycle early, so the bench forces such a collision on purpose. The five-instruction sequence checks issue cycles, stall cycles and completion order cycle by cycle against hand-computed timing.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  localparam int NUM_UNITS = 2;

  typedef enum logic {
    UNIT_SHORT = 1'b0,
    UNIT_LONG  = 1'b1
  } unit_sel_e;
endpackage

// File: rtl/exec_unit.sv
// One non-pipelined execute slot: carries a tag for LAT cycles, then holds
// it at count 1 until the output takes it.
module exec_unit #(
  parameter int TAG_W = 4,
  parameter int LAT   = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic             take,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] rem,
  output logic [TAG_W-1:0] tag
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [TAG_W-1:0] tag_q;
  logic             rem_en;

  always_comb begin
    rem_d  = rem_q;
    rem_en = 1'b0;
    if (start) begin
      rem_d  = CNT_W'(LAT);
      rem_en = 1'b1;
    end else if (take) begin
      rem_d  = '0;
      rem_en = 1'b1;
    end else if (rem_q > CNT_W'(1)) begin
      rem_d  = rem_q - CNT_W'(1);
      rem_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (start) begin
      tag_q <= start_tag;
    end
  end

  assign busy = (rem_q != '0);
  assign last = (rem_q == CNT_W'(1));
  assign rem  = rem_q;
  assign tag  = tag_q;
endmodule

// File: rtl/drain_arb.sv
// Picks which finished unit drives the output; tracks which unit holds the
// older instruction.
module drain_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] last,
  input  logic [1:0] busy,
  input  logic [1:0] start,
  output logic [1:0] grant
);
  logic older_q, older_d;
  logic older_en;

  always_comb begin
    grant[0] = last[0] && (!last[1] || !older_q);
    grant[1] = last[1] && (!last[0] ||  older_q);
  end

  always_comb begin
    older_en = |start;
    older_d  = older_q;
    if (start[0]) begin
      older_d = busy[1] && !grant[1];
    end else if (start[1]) begin
      older_d = !(busy[0] && !grant[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= 1'b0;
    end else if (older_en) begin
      older_q <= older_d;
    end
  end
endmodule

// File: rtl/dual_exec_sched.sv
module dual_exec_sched
  import dxs_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LAT_A = 2,
  parameter int LAT_B = 4,
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B,
  localparam int CNT_W = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [TAG_W-1:0] dec_tag,
  input  logic             dec_unit,
  output logic             stall,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             done_unit,
  output logic [1:0]       unit_busy,
  output logic [CNT_W-1:0] rem_a,
  output logic [CNT_W-1:0] rem_b
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_UNITS-1:0] u_start, u_last, u_busy, u_grant;
  logic [CNT_W-1:0]     u_rem [NUM_UNITS];
  logic [TAG_W-1:0]     u_tag [NUM_UNITS];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    localparam int   LAT = (g == 0) ? LAT_A : LAT_B;
    localparam logic SEL = (g == 0) ? UNIT_SHORT : UNIT_LONG;

    assign u_start[g] = dec_valid && (dec_unit == SEL) &&
                        (!u_busy[g] || u_grant[g]);

    exec_unit #(
      .TAG_W(TAG_W),
      .LAT  (LAT),
      .CNT_W(CNT_W)
    ) i_unit (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .start    (u_start[g]),
      .start_tag(dec_tag),
      .take     (u_grant[g]),
      .busy     (u_busy[g]),
      .last     (u_last[g]),
      .rem      (u_rem[g]),
      .tag      (u_tag[g])
    );
  end

  drain_arb i_arb (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .last (u_last),
    .busy (u_busy),
    .start(u_start),
    .grant(u_grant)
  );

  assign stall      = dec_valid && !(|u_start);
  assign done_valid = |u_grant;
  assign done_unit  = u_grant[1];
  assign done_tag   = u_grant[1] ? u_tag[1] : u_tag[0];
  assign unit_busy  = u_busy;
  assign rem_a      = u_rem[0];
  assign rem_b      = u_rem[1];
endmodule

// File: rtl/dual_exec_sched_chk.sv
module dual_exec_sched_chk #(
  parameter int LAT_A = 2,
  parameter int LAT_B = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dec_unit,
  input logic             stall,
  input logic             done_valid,
  input logic             done_unit,
  input logic [1:0]       unit_busy,
  input logic [CNT_W-1:0] rem_a,
  input logic [CNT_W-1:0] rem_b
);
  a_r3_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dec_valid);

  a_r3_stall_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dec_unit ? (rem_b != '0) : (rem_a != '0)));

  a_r4_load_short: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall && !dec_unit) |=> (rem_a == CNT_W'(LAT_A)));

  a_r4_load_long: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall && dec_unit) |=> (rem_b == CNT_W'(LAT_B)));

  a_r5_step_short: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_a > CNT_W'(1)) |=> (rem_a == $past(rem_a) - CNT_W'(1)));

  a_r5_step_long: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_b > CNT_W'(1)) |=> (rem_b == $past(rem_b) - CNT_W'(1)));

  a_r5_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_busy[0] == (rem_a != '0)) && (unit_busy[1] == (rem_b != '0)));

  a_r6_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_unit ? (rem_b == CNT_W'(1)) : (rem_a == CNT_W'(1))));

  a_r6_final_drains: assert property (@(posedge clk) disable iff (!rst_n)
    ((rem_a == CNT_W'(1)) || (rem_b == CNT_W'(1))) |-> done_valid);

  a_r7_hold_short: assert property (@(posedge clk) disable iff (!rst_n)
    ((rem_a == CNT_W'(1)) && !(done_valid && !done_unit)) |=> (rem_a == CNT_W'(1)));

  a_r7_hold_long: assert property (@(posedge clk) disable iff (!rst_n)
    ((rem_b == CNT_W'(1)) && !(done_valid && done_unit)) |=> (rem_b == CNT_W'(1)));
endmodule

bind dual_exec_sched dual_exec_sched_chk #(
  .LAT_A(LAT_A),
  .LAT_B(LAT_B),
  .CNT_W(CNT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .dec_valid (dec_valid),
  .dec_unit  (dec_unit),
  .stall     (stall),
  .done_valid(done_valid),
  .done_unit (done_unit),
  .unit_busy (unit_busy),
  .rem_a     (rem_a),
  .rem_b     (rem_b)
);

// File: tb/test_dual_exec_sched.sv
module test_dual_exec_sched;
  localparam int CLK_P = 10;
  localparam int TAG_W = 4;
  localparam int CNT_W = 3;
  localparam int NROWS = 11;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dec_valid;
  logic [TAG_W-1:0] dec_tag;
  logic             dec_unit;
  logic             stall;
  logic             done_valid;
  logic [TAG_W-1:0] done_tag;
  logic             done_unit;
  logic [1:0]       unit_busy;
  logic [CNT_W-1:0] rem_a;
  logic [CNT_W-1:0] rem_b;

  int errors = 0;
  int checks = 0;

  always #(CLK_P / 2) clk = ~clk;

  dual_exec_sched #(.TAG_W(TAG_W), .LAT_A(2), .LAT_B(4)) i_dual_exec_sched (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_tag(dec_tag),
    .dec_unit(dec_unit), .stall(stall), .done_valid(done_valid),
    .done_tag(done_tag), .done_unit(done_unit), .unit_busy(unit_busy),
    .rem_a(rem_a), .rem_b(rem_b)
  );

  // Row: valid, unit(R8: 0 short, 1 long), tag, stall, done_valid, done_tag,
  // done_unit, rem_a, rem_b. Sequence short,long,short,long,short, tags 1..5.
  localparam logic [18:0] TBL [NROWS] = '{
    {1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0, 3'd0},
    {1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 4'd0, 1'b0, 3'd2, 3'd0},
    {1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 4'd1, 1'b0, 3'd1, 3'd4},
    {1'b1, 1'b1, 4'd4, 1'b1, 1'b0, 4'd0, 1'b0, 3'd2, 3'd3},
    {1'b1, 1'b1, 4'd4, 1'b1, 1'b1, 4'd3, 1'b0, 3'd1, 3'd2},
    {1'b1, 1'b1, 4'd4, 1'b0, 1'b1, 4'd2, 1'b1, 3'd0, 3'd1},
    {1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0, 3'd4},
    {1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd2, 3'd3},
    {1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd5, 1'b0, 3'd1, 3'd2},
    {1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd4, 1'b1, 3'd0, 3'd1},
    {1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive decode for one cycle and let outputs settle before sampling.
  task automatic step(input logic v, input logic u, input logic [TAG_W-1:0] t);
    @(negedge clk);
    dec_valid = v;
    dec_unit  = u;
    dec_tag   = t;
    #1;
  endtask

  task automatic chk_idle(input string req);
    chk({req, " rem_a"}, int'(rem_a), 0);
    chk({req, " rem_b"}, int'(rem_b), 0);
    chk({req, " busy"}, int'(unit_busy), 0);
    chk({req, " done_valid"}, int'(done_valid), 0);
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dec_valid = 1'b0;
    dec_unit = 1'b0;
    dec_tag = '0;
    repeat (3) @(negedge clk);
    #1;
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk_idle("R1 after release");

    // Table walk: five-instruction sequence, cycle by cycle.
    for (int i = 0; i < NROWS; i++) begin
      step(TBL[i][18], TBL[i][17], TBL[i][16:13]);
      chk($sformatf("R3 R2 stall row %0d", i), int'(stall), int'(TBL[i][12]));
      chk($sformatf("R4 R6 done_valid row %0d", i), int'(done_valid), int'(TBL[i][11]));
      if (TBL[i][11]) begin
        chk($sformatf("R6 done_tag row %0d", i), int'(done_tag), int'(TBL[i][10:7]));
        chk($sformatf("R6 R8 done_unit row %0d", i), int'(done_unit), int'(TBL[i][6]));
      end
      chk($sformatf("R5 rem_a row %0d", i), int'(rem_a), int'(TBL[i][5:3]));
      chk($sformatf("R5 rem_b row %0d", i), int'(rem_b), int'(TBL[i][2:0]));
      chk($sformatf("R5 R8 busy row %0d", i), int'(unit_busy),
          int'({TBL[i][2:0] != 3'd0, TBL[i][5:3] != 3'd0}));
    end

    // Collision: long op tag 8, then short op tag 9 two cycles later.
    step(1'b1, 1'b1, 4'd8);
    chk("R2 long issue", int'(stall), 0);
    step(1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd9);
    chk("R2 short issue", int'(stall), 0);
    step(1'b0, 1'b0, 4'd0);
    chk("R5 rem_a before collision", int'(rem_a), 2);
    chk("R5 rem_b before collision", int'(rem_b), 2);
    step(1'b1, 1'b0, 4'd10);
    chk("R7 older first valid", int'(done_valid), 1);
    chk("R7 older first tag", int'(done_tag), 8);
    chk("R7 older first unit", int'(done_unit), 1);
    chk("R7 stall behind held unit", int'(stall), 1);
    step(1'b1, 1'b0, 4'd10);
    chk("R7 held result tag", int'(done_tag), 9);
    chk("R7 held result unit", int'(done_unit), 0);
    chk("R7 held rem_a", int'(rem_a), 1);
    chk("R5 long drained", int'(rem_b), 0);
    chk("R2 accept while draining", int'(stall), 0);
    step(1'b0, 1'b0, 4'd0);
    chk("R4 new short op loaded", int'(rem_a), 2);
    chk("R6 no output between", int'(done_valid), 0);
    step(1'b0, 1'b0, 4'd0);
    chk("R4 tag 10 done", int'(done_tag), 10);
    chk("R4 tag 10 valid", int'(done_valid), 1);
    step(1'b0, 1'b0, 4'd0);
    chk("R5 short idle again", int'(rem_a), 0);
    chk("R3 no stall when invalid", int'(stall), 0);

    // Reset in the middle of a long operation.
    step(1'b1, 1'b1, 4'd11);
    step(1'b0, 1'b0, 4'd0);
    chk("R5 long busy before reset", int'(rem_b), 4);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 mid-run reset");
    step(1'b0, 1'b0, 4'd0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 4'd0);
    chk_idle("R1 after second release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule